// File: doc/BRIEF.md
# Serial OSD Command Decoder

This block is the command front end of an on-screen display controller. A host writes 8-bit bytes over a three-wire serial port: an active-low select, a shift clock and a data line. The block turns each byte into parallel form and decides whether it opens a new command or carries data for the command already open. It keeps that command open across any number of data bytes. It also keeps a write pointer into a 12-row by 24-column character memory and loads a bank of configuration slots for the display, sync and line-colour commands.

A character-write command locks the decoder. From then on, every byte is a character code, whatever its top bit. Each code becomes a one-cycle memory write request carrying row, column, code and an attribute flag, and the pointer then advances. Releasing the select line ends the lock and returns the decoder to address setup. The serial pins are oversampled by the system clock, so the host's shift clock must run well below it.

Top module: `osd_cmd_decoder`

## Requirements
- R1: After reset, `cmd_o`, `cur_row_o`, `cur_col_o`, every configuration slot and every write output are zero, and no write request is issued.
- R2: A byte is shifted in most significant bit first, on eight rising edges of `ser_clk` while `ser_cs_n` is low. A partial byte is discarded when `ser_cs_n` goes high.
- R3: A byte with bit 7 set opens a command chosen by bits 7..4, shown on `cmd_o`: 1000 gives 0 (address setup), 1001 gives 1 (character write), 1010 gives 2, 1011 gives 3, 1100 gives 4, 1101 gives 5 and 1110 gives 6.
- R4: When bits 7..4 are 1111, bits 3..2 equal to 00, 01, 10 and 11 open commands 7, 8, 9 and 10.
- R5: For commands 2 to 10 (slot = command − 2), the opening byte stores its bits 3..0 in nibble slot `cfg_nib_o[4*slot +: 4]`. Each data byte (bit 7 clear) stores its bits 6..0 in `cfg_dat_o[7*slot +: 7]`. The command stays open across data bytes, so the last one wins.
- R6: Command 0's opening byte sets the row pointer from bits 3..0. Each of its data bytes sets the column pointer from bits 4..0.
- R7: Command 1's opening byte latches bit 0 as the attribute. Every later byte produces a one-cycle `wr_en_o` with the pointer's row and column, the byte as `wr_code_o`, and the latched attribute.
- R8: While command 1 is open, bytes with bit 7 set (including FE and FF) are written as character codes and do not change `cmd_o`.
- R9: `ser_cs_n` high returns `cmd_o` to 0 and ends the character-write lock. Pointer and slots keep their values.
- R10: After each write the column advances by one. Past column 23 it wraps to 0 and the row advances, and row 11 wraps to row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| cmd_o | output | 4 | Open command index 0..10 |
| wr_en_o | output | 1 | Character memory write strobe |
| wr_row_o | output | 4 | Row of the write |
| wr_col_o | output | 5 | Column of the write |
| wr_code_o | output | 8 | Character code of the write |
| wr_attr_o | output | 1 | Attribute flag of the write |
| cur_row_o | output | 4 | Row pointer for the next write |
| cur_col_o | output | 5 | Column pointer for the next write |
| cfg_nib_o | output | 36 | Nine nibble slots, commands 2..10 |
| cfg_dat_o | output | 63 | Nine 7-bit data slots, commands 2..10 |

## Verification
A bit counter that slips shows up on the next full byte: the row, column or slot value comes out shifted, or a command is decoded wrongly, within one byte time. A lost or missed lock shows up at once in the scoreboard: a high-bit character byte either opens a command and produces no write, or produces a write outside command 1. A pointer fault becomes visible at the next write strobe and at the pointer ports one cycle after each write, which is why the row and column wraps are driven explicitly.

// File: rtl/osd_pkg.sv
package osd_pkg;
    localparam int BYTE_W   = 8;
    localparam int CMD_W    = 4;
    localparam int NIB_W    = 4;
    localparam int DAT_W    = 7;
    localparam int FIRST_CFG = 2;
    localparam int NREG     = 9;

    localparam logic [CMD_W-1:0] CMD_ADDR = 4'd0;
    localparam logic [CMD_W-1:0] CMD_CHAR = 4'd1;

    function automatic logic [CMD_W-1:0] decode_cmd(input logic [BYTE_W-1:0] b);
        logic [CMD_W-1:0] idx;
        case (b[7:4])
            4'h8:    idx = 4'd0;
            4'h9:    idx = 4'd1;
            4'hA:    idx = 4'd2;
            4'hB:    idx = 4'd3;
            4'hC:    idx = 4'd4;
            4'hD:    idx = 4'd5;
            4'hE:    idx = 4'd6;
            default: idx = 4'd7 + {2'b00, b[3:2]};
        endcase
        return idx;
    endfunction
endpackage

// File: rtl/osd_serial_rx.sv
module osd_serial_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              cs_idle_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [1:0]        cs;
        logic [2:0]        sck;
        logic [1:0]        sdi;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [BYTE_W-1:0] data;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d       = q;
        d.cs    = {q.cs[0], cs_n_i};
        d.sck   = {q.sck[1:0], sck_i};
        d.sdi   = {q.sdi[0], sdi_i};
        d.vld   = 1'b0;
        if (q.cs[1]) begin
            d.cnt = '0;
        end else if (q.sck[1] && !q.sck[2]) begin
            d.sh = {q.sh[BYTE_W-2:0], q.sdi[1]};
            if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                d.vld  = 1'b1;
                d.data = {q.sh[BYTE_W-2:0], q.sdi[1]};
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs   <= '1;
            q.sck  <= '1;
        end else begin
            q <= d;
        end
    end

    assign byte_vld_o = q.vld;
    assign byte_o     = q.data;
    assign cs_idle_o  = q.cs[1];
endmodule

// File: rtl/osd_addr_ctr.sv
module osd_addr_ctr #(
    parameter int ROWS = 12,
    parameter int COLS = 24,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_row_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             load_col_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             step_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } ptr_t;

    ptr_t q, d;

    always_comb begin
        d = q;
        if (load_row_i) d.row = row_i;
        if (load_col_i) d.col = col_i;
        if (step_i) begin
            if (q.col >= COL_W'(COLS - 1)) begin
                d.col = '0;
                d.row = (q.row >= ROW_W'(ROWS - 1)) ? '0 : q.row + 1'b1;
            end else begin
                d.col = q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign row_o = q.row;
    assign col_o = q.col;
endmodule

// File: rtl/osd_cfg_bank.sv
module osd_cfg_bank #(
    parameter int NREG  = 9,
    parameter int NIB_W = 4,
    parameter int DAT_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0]        nib_we_i,
    input  logic [NREG-1:0]        dat_we_i,
    input  logic [NIB_W-1:0]       nib_i,
    input  logic [DAT_W-1:0]       dat_i,
    output logic [NREG*NIB_W-1:0]  nib_o,
    output logic [NREG*DAT_W-1:0]  dat_o
);
    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic [DAT_W-1:0] dat;
    } slot_t;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        slot_t q, d;

        always_comb begin
            d = q;
            if (nib_we_i[g]) d.nib = nib_i;
            if (dat_we_i[g]) d.dat = dat_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        assign nib_o[g*NIB_W +: NIB_W] = q.nib;
        assign dat_o[g*DAT_W +: DAT_W] = q.dat;
    end
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
    import osd_pkg::*;
#(
    parameter int ROWS  = 12,
    parameter int COLS  = 24,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_cs_n,
    input  logic                  ser_clk,
    input  logic                  ser_dat,
    output logic [CMD_W-1:0]      cmd_o,
    output logic                  wr_en_o,
    output logic [ROW_W-1:0]      wr_row_o,
    output logic [COL_W-1:0]      wr_col_o,
    output logic [BYTE_W-1:0]     wr_code_o,
    output logic                  wr_attr_o,
    output logic [ROW_W-1:0]      cur_row_o,
    output logic [COL_W-1:0]      cur_col_o,
    output logic [NREG*NIB_W-1:0] cfg_nib_o,
    output logic [NREG*DAT_W-1:0] cfg_dat_o
);
    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic              attr;
        logic              we;
        logic [ROW_W-1:0]  wrow;
        logic [COL_W-1:0]  wcol;
        logic [BYTE_W-1:0] code;
    } dec_t;

    dec_t q, d;

    logic              byte_vld;
    logic [BYTE_W-1:0] rx_byte;
    logic              cs_idle;
    logic              load_row, load_col, step;
    logic [NREG-1:0]   nib_we, dat_we;
    logic [CMD_W-1:0]  new_cmd;
    logic [CMD_W-1:0]  new_slot, cur_slot;

    osd_serial_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (ser_cs_n),
        .sck_i      (ser_clk),
        .sdi_i      (ser_dat),
        .byte_vld_o (byte_vld),
        .byte_o     (rx_byte),
        .cs_idle_o  (cs_idle)
    );

    assign new_cmd  = decode_cmd(rx_byte);
    assign new_slot = new_cmd - CMD_W'(FIRST_CFG);
    assign cur_slot = q.cmd - CMD_W'(FIRST_CFG);

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        load_row = 1'b0;
        load_col = 1'b0;
        step     = 1'b0;
        nib_we   = '0;
        dat_we   = '0;
        if (cs_idle) begin
            d.cmd = CMD_ADDR;
        end else if (byte_vld) begin
            if (q.cmd == CMD_CHAR) begin
                d.we   = 1'b1;
                d.wrow = cur_row_o;
                d.wcol = cur_col_o;
                d.code = rx_byte;
                step   = 1'b1;
            end else if (rx_byte[BYTE_W-1]) begin
                d.cmd = new_cmd;
                if (new_cmd == CMD_ADDR)      load_row = 1'b1;
                else if (new_cmd == CMD_CHAR) d.attr = rx_byte[0];
                else                          nib_we = NREG'(1) << new_slot;
            end else begin
                if (q.cmd == CMD_ADDR) load_col = 1'b1;
                else                   dat_we = NREG'(1) << cur_slot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    osd_addr_ctr #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_row_i (load_row),
        .row_i      (rx_byte[ROW_W-1:0]),
        .load_col_i (load_col),
        .col_i      (rx_byte[COL_W-1:0]),
        .step_i     (step),
        .row_o      (cur_row_o),
        .col_o      (cur_col_o)
    );

    osd_cfg_bank #(.NREG(NREG), .NIB_W(NIB_W), .DAT_W(DAT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .nib_we_i (nib_we),
        .dat_we_i (dat_we),
        .nib_i    (rx_byte[NIB_W-1:0]),
        .dat_i    (rx_byte[DAT_W-1:0]),
        .nib_o    (cfg_nib_o),
        .dat_o    (cfg_dat_o)
    );

    assign cmd_o     = q.cmd;
    assign wr_en_o   = q.we;
    assign wr_row_o  = q.wrow;
    assign wr_col_o  = q.wcol;
    assign wr_code_o = q.code;
    assign wr_attr_o = q.attr;
endmodule

// File: rtl/osd_cmd_decoder_chk.sv
module osd_cmd_decoder_chk #(
    parameter int COLS  = 24,
    parameter int ROW_W = 4,
    parameter int COL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_cs_n,
    input logic [3:0]       cmd_o,
    input logic             wr_en_o,
    input logic [COL_W-1:0] wr_col_o,
    input logic [ROW_W-1:0] wr_row_o,
    input logic [ROW_W-1:0] cur_row_o,
    input logic [COL_W-1:0] cur_col_o
);
    // R7: a write request lasts a single cycle
    p_we_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R7: writes are produced only with the character command open
    p_we_in_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> cmd_o == 4'd1);

    // R8: the lock is left only towards address setup
    p_lock_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_o) == 4'd1 && cmd_o != 4'd1) |-> cmd_o == 4'd0);

    // R9: select held high brings the command back to address setup
    p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_cs_n && $past(ser_cs_n) && $past(ser_cs_n, 2) && $past(ser_cs_n, 3))
        |-> cmd_o == 4'd0);

    // R10: the pointer moves one step past the written column
    p_col_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((wr_col_o >= COL_W'(COLS - 1)) ? (cur_col_o == '0)
                     : (cur_col_o == wr_col_o + 1'b1 && cur_row_o == wr_row_o)));
endmodule

bind osd_cmd_decoder osd_cmd_decoder_chk #(
    .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_cs_n  (ser_cs_n),
    .cmd_o     (cmd_o),
    .wr_en_o   (wr_en_o),
    .wr_col_o  (wr_col_o),
    .wr_row_o  (wr_row_o),
    .cur_row_o (cur_row_o),
    .cur_col_o (cur_col_o)
);

// File: tb/tb_osd_cmd_decoder.sv
module tb_osd_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_cs_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic        ser_dat = 1'b0;
    logic [3:0]  cmd_o;
    logic        wr_en_o;
    logic [3:0]  wr_row_o;
    logic [4:0]  wr_col_o;
    logic [7:0]  wr_code_o;
    logic        wr_attr_o;
    logic [3:0]  cur_row_o;
    logic [4:0]  cur_col_o;
    logic [35:0] cfg_nib_o;
    logic [62:0] cfg_dat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [17:0] exp_q[$];
    int m_row = 0;
    int m_col = 0;
    logic m_attr = 1'b0;

    always #4 clk = ~clk;

    osd_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .cmd_o(cmd_o), .wr_en_o(wr_en_o),
        .wr_row_o(wr_row_o), .wr_col_o(wr_col_o), .wr_code_o(wr_code_o),
        .wr_attr_o(wr_attr_o), .cur_row_o(cur_row_o), .cur_col_o(cur_col_o),
        .cfg_nib_o(cfg_nib_o), .cfg_dat_o(cfg_dat_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            ser_clk = 1'b0;
            ser_dat = b[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
        end
        wait_clk(4);
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic sel;
        ser_cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic desel;
        wait_clk(2);
        ser_cs_n = 1'b1;
        wait_clk(8);
    endtask

    // driver: pushes the expected write, then sends the character byte
    task automatic put_char(input logic [7:0] code);
        exp_q.push_back({4'(m_row), 5'(m_col), code, m_attr});
        if (m_col >= 23) begin
            m_col = 0;
            m_row = (m_row >= 11) ? 0 : m_row + 1;
        end else begin
            m_col++;
        end
        send_byte(code);
    endtask

    function automatic logic [3:0] nib(input int slot);
        return cfg_nib_o[slot*4 +: 4];
    endfunction

    function automatic logic [6:0] dat(input int slot);
        return cfg_dat_o[slot*7 +: 7];
    endfunction

    // monitor: pops and compares every write the design issues
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7: actual write %0h/%0h/%0h expected none",
                         wr_row_o, wr_col_o, wr_code_o);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                if ({wr_row_o, wr_col_o, wr_code_o, wr_attr_o} !== e) begin
                    errors++;
                    $display("FAIL R7/R8/R10: actual %0h expected %0h",
                             {wr_row_o, wr_col_o, wr_code_o, wr_attr_o}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        chk("R1 cmd", 32'(cmd_o), 0);
        chk("R1 ptr", {cur_row_o, cur_col_o}, 0);
        chk("R1 nib", 32'(cfg_nib_o[31:0]), 0);
        chk("R1 dat", 32'(cfg_dat_o[31:0]), 0);
        chk("R1 we", 32'(wr_en_o), 0);

        // R6 / R2: address setup
        sel; send_byte(8'h85); send_byte(8'h0A); desel;
        chk("R6 row", 32'(cur_row_o), 5);
        chk("R6 col", 32'(cur_col_o), 10);
        m_row = 5; m_col = 10;

        // R7 / R8: character lock with attribute set
        sel; send_byte(8'h91); m_attr = 1'b1;
        put_char(8'h41); put_char(8'hFE); put_char(8'h9C); put_char(8'hFF);
        chk("R8 still locked", 32'(cmd_o), 1);
        desel;
        chk("R9 release", 32'(cmd_o), 0);
        chk("R10 ptr after 4", {cur_row_o, cur_col_o}, {4'd5, 5'd14});

        // R10: column and row wrap at the bottom-right corner
        sel; send_byte(8'h8B); send_byte(8'h16); send_byte(8'h90); m_row = 11; m_col = 22; m_attr = 1'b0;
        put_char(8'h01); put_char(8'h02); put_char(8'h03);
        desel;
        chk("R10 wrap ptr", {cur_row_o, cur_col_o}, {4'd0, 5'd1});

        // R10: column wrap mid-screen
        sel; send_byte(8'h83); send_byte(8'h17); send_byte(8'h90); m_row = 3; m_col = 23;
        put_char(8'h55);
        desel;
        chk("R10 row step", {cur_row_o, cur_col_o}, {4'd4, 5'd0});

        // R3 / R5: commands 2..6, several data bytes on one code
        sel;
        send_byte(8'hA5); chk("R3 cmd2", 32'(cmd_o), 2);
        send_byte(8'h33); send_byte(8'h7F);
        send_byte(8'hB2); send_byte(8'h21); chk("R3 cmd3", 32'(cmd_o), 3);
        send_byte(8'hC9); send_byte(8'h12); chk("R3 cmd4", 32'(cmd_o), 4);
        send_byte(8'hD4); send_byte(8'h44);
        send_byte(8'hE6); send_byte(8'h66); chk("R3 cmd6", 32'(cmd_o), 6);
        // R4: extended commands
        send_byte(8'hF1); send_byte(8'h07); chk("R4 cmd7", 32'(cmd_o), 7);
        send_byte(8'hF6); send_byte(8'h08); chk("R4 cmd8", 32'(cmd_o), 8);
        send_byte(8'hFA); send_byte(8'h09); chk("R4 cmd9", 32'(cmd_o), 9);
        send_byte(8'hFD); send_byte(8'h5A); chk("R4 cmd10", 32'(cmd_o), 10);
        desel;
        chk("R5 nib slot0", 32'(nib(0)), 5);
        chk("R5 last data wins", 32'(dat(0)), 32'h7F);
        chk("R5 slot1", {nib(1), dat(1)}, {4'h2, 7'h21});
        chk("R5 slot2", {nib(2), dat(2)}, {4'h9, 7'h12});
        chk("R5 slot3", {nib(3), dat(3)}, {4'h4, 7'h44});
        chk("R5 slot4", {nib(4), dat(4)}, {4'h6, 7'h66});
        chk("R4 slot5", {nib(5), dat(5)}, {4'h1, 7'h07});
        chk("R4 slot6", {nib(6), dat(6)}, {4'h6, 7'h08});
        chk("R4 slot7", {nib(7), dat(7)}, {4'hA, 7'h09});
        chk("R4 slot8", {nib(8), dat(8)}, {4'hD, 7'h5A});

        // R2: partial byte dropped on release
        sel; send_bits(8'hA0, 4); desel;
        sel; send_byte(8'h87); send_byte(8'h05); desel;
        chk("R2 partial dropped row", 32'(cur_row_o), 7);
        chk("R2 partial dropped col", 32'(cur_col_o), 5);

        // R9: release after a config command, data then goes to address setup
        sel; send_byte(8'hA1); desel;
        sel; send_byte(8'h0C); desel;
        chk("R9 col after release", 32'(cur_col_o), 12);
        chk("R9 slot0 data kept", 32'(dat(0)), 32'h7F);
        chk("R9 slot0 nib", 32'(nib(0)), 1);

        wait_clk(10);
        chk("R7 all writes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule